// File: doc/BRIEF.md
# USB Type-C Port Attach and Role Controller

This block is the digital half of a single USB Type-C port. Analog comparators outside it classify each configuration-channel line into a small code (open, Ra, Rd, or a pull-up at one of three current levels), and a separate comparator reports whether VBUS is present. From these inputs the block decides whether a partner is attached, which role the port takes, and which way the cable is plugged in. It then drives the select line of the SuperSpeed 2:1 mux and a set of active-low status lines.

A three-level strap chooses the role: source only, sink only, or dual-role. The strap is captured when the controller is enabled and when a soft reset is requested. In dual-role mode the block alternates between a pull-up and a pull-down presentation until a partner has been seen for a debounce interval. As a source it advertises the level taken from a three-level current input. As a sink it reports the level the partner advertises on two status lines. An audio adapter, seen as Ra on both lines, gets its own indicator.

Top module: `tcpc_port_ctrl`

## Requirements
- R1: The strap is decoded as 2'b10 = source only, 2'b00 = sink only, and 2'b01 or 2'b11 = dual-role. It is captured at the clock edge where the controller becomes active (`cc_en_n` low and `supply_ok` high). While active, `term_on` is high, and `term_src` is 1 when presenting a pull-up and 0 when presenting Rd.
- R2: While the controller stays active, a change of `role_strap` has no effect until `soft_rst_req` is pulsed. The pulse recaptures the strap and returns the port to unattached.
- R3: In dual-role mode, while unattached with no candidate partner, `term_src` repeats with a period of TOGGLE_PERIOD cycles, high for exactly half of them.
- R4: The line codes are 0 open, 1 Ra, 2 Rd, 3 pull-up default, 4 pull-up 1.5 A, 5 pull-up 3 A; codes 6 and 7 count as open. While presenting a pull-up, if exactly one line reads Rd and the other reads open or Ra, and this holds for more than DEBOUNCE cycles, the port attaches as source. The port does not attach before DEBOUNCE cycles have passed. `mux_sel` is 1 and `flip_n` is 0 when the attaching line is line 2; otherwise `mux_sel` is 0 and `flip_n` is 1.
- R5: `src_att_n` is low only while attached as source, whether the role is source-only or dual-role resolved to source.
- R6: While presenting Rd, the port attaches as sink only if exactly one line reads a pull-up and `vbus_ok` is high. Attached as sink, `snk_med_n` is low for the 1.5 A and 3 A levels, and `snk_high_n` is low only for the 3 A level. Both lines are high in every other state.
- R7: `rp_level` is 0, 1 or 2 when `adv_level` is 0, 1, or 2/3 while presenting a pull-up. It stays 0 while presenting Rd, whatever `adv_level` is.
- R8: Ra on both lines while presenting a pull-up, held through the debounce, drives `audio_n` low. It leaves `src_att_n` high and `mux_on` low.
- R9: `mux_on` is high only while attached as source or sink with `mux_en_n` low. `mux_en_n` high forces `mux_on` low.
- R10: Loss of the partner's termination, or loss of VBUS while attached as sink, returns the port to unattached within two cycles. This releases `src_att_n`, `flip_n` and `audio_n` high, and a dual-role port resumes toggling.
- R11: While `cc_en_n` is high or `supply_ok` is low, the port presents no termination and reports unattached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cc_en_n | input | 1 | Active-low controller enable |
| supply_ok | input | 1 | Supply valid |
| soft_rst_req | input | 1 | One-cycle soft reset request (recaptures the strap) |
| role_strap | input | 2 | Role strap: 00 low, 01 open, 10 high |
| cc1_st | input | 3 | Classified state of CC line 1 |
| cc2_st | input | 3 | Classified state of CC line 2 |
| vbus_ok | input | 1 | VBUS present |
| adv_level | input | 2 | Current level to advertise as source |
| mux_en_n | input | 1 | Active-low mux enable |
| term_on | output | 1 | A termination is presented |
| term_src | output | 1 | 1 = pull-up presented, 0 = Rd presented |
| rp_level | output | 2 | Pull-up level presented (0 default, 1 1.5 A, 2 3 A) |
| attached | output | 1 | Any attached state |
| mux_sel | output | 1 | SuperSpeed mux select (1 = line 2) |
| mux_on | output | 1 | Mux path enabled |
| src_att_n | output | 1 | Low when attached as source |
| flip_n | output | 1 | Low when a data attach uses line 2 |
| snk_med_n | output | 1 | Low for 1.5 A or 3 A seen as sink |
| snk_high_n | output | 1 | Low for 3 A seen as sink |
| audio_n | output | 1 | Low when an audio adapter is attached |

## Verification
The hardest situation to reach is a dual-role attach. The partner's termination is only visible during the half of the toggle cycle whose presentation complements it, and the toggle must then freeze long enough for the debounce to finish. The bench models each partner as a function of the presented termination, so a sink, a source or an audio adapter appears only in the matching phase, and the bench waits for the attach wherever the toggle happens to stand. Randomized line codes under the fixed source and sink roles cover mixed terminations, such as Rd beside a pull-up or Rd on both lines, that must not attach.

// File: rtl/tcpc_pkg.sv
package tcpc_pkg;

   typedef enum logic [1:0] {
      ROLE_SNK = 2'd0,
      ROLE_DRP = 2'd1,
      ROLE_SRC = 2'd2
   } role_e;

   typedef enum logic [1:0] {
      ST_UNATT = 2'd0,
      ST_SRC   = 2'd1,
      ST_SNK   = 2'd2,
      ST_AUD   = 2'd3
   } att_e;

   localparam int CC_W = 3;

   localparam logic [CC_W-1:0] CC_OPEN   = 3'd0;
   localparam logic [CC_W-1:0] CC_RA     = 3'd1;
   localparam logic [CC_W-1:0] CC_RD     = 3'd2;
   localparam logic [CC_W-1:0] CC_RP_DEF = 3'd3;
   localparam logic [CC_W-1:0] CC_RP_MED = 3'd4;
   localparam logic [CC_W-1:0] CC_RP_HI  = 3'd5;

   typedef struct packed {
      att_e kind;
      logic orient;
   } cand_t;

   function automatic logic is_ra(input logic [CC_W-1:0] c);
      return c == CC_RA;
   endfunction

   function automatic logic is_rd(input logic [CC_W-1:0] c);
      return c == CC_RD;
   endfunction

   function automatic logic is_rp(input logic [CC_W-1:0] c);
      return (c == CC_RP_DEF) || (c == CC_RP_MED) || (c == CC_RP_HI);
   endfunction

   function automatic logic [1:0] rp_to_lvl(input logic [CC_W-1:0] c);
      if (c == CC_RP_HI)  return 2'd2;
      if (c == CC_RP_MED) return 2'd1;
      return 2'd0;
   endfunction

   function automatic role_e decode_strap(input logic [1:0] s);
      case (s)
         2'b00:   return ROLE_SNK;
         2'b10:   return ROLE_SRC;
         default: return ROLE_DRP;
      endcase
   endfunction

endpackage

// File: rtl/tcpc_role_latch.sv
module tcpc_role_latch
   import tcpc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cc_en_n,
   input  logic       supply_ok,
   input  logic       soft_rst_req,
   input  logic [1:0] role_strap,
   output logic       run,
   output logic       restart,
   output role_e      role
);

   logic  active, active_q;
   role_e role_q;

   assign active  = !cc_en_n && supply_ok;
   assign restart = (active && !active_q) || (active && active_q && soft_rst_req);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         role_q   <= ROLE_DRP;
      end else begin
         active_q <= active;
         if (restart) role_q <= decode_strap(role_strap);
      end
   end

   assign run  = active_q;
   assign role = role_q;

   assert_strap_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && $past(active_q) && !$past(soft_rst_req)) |-> (role_q == $past(role_q)));

endmodule

// File: rtl/tcpc_drp_toggle.sv
module tcpc_drp_toggle #(
   parameter int PERIOD    = 32,
   parameter bit START_SRC = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic hold,
   output logic phase_src
);

   localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
   localparam int HALF  = PERIOD / 2;
   localparam logic [CNT_W-1:0] LAST   = CNT_W'(PERIOD - 1);
   localparam logic [CNT_W-1:0] HALF_C = CNT_W'(HALF);

   generate
      if (PERIOD < 2 || (PERIOD % 2) != 0) begin : g_bad_period
         $error("tcpc_drp_toggle: PERIOD must be even and at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (!run)     cnt <= '0;
      else if (!hold)    cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
   end

   generate
      if (START_SRC) begin : g_src_first
         assign phase_src = (cnt < HALF_C);
      end else begin : g_snk_first
         assign phase_src = (cnt >= HALF_C);
      end
   endgenerate

   assert_hold_freezes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run) && run && $past(hold)) |-> $stable(phase_src));

endmodule

// File: rtl/tcpc_attach_fsm.sv
module tcpc_attach_fsm
   import tcpc_pkg::*;
#(
   parameter int DEBOUNCE = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            restart,
   input  role_e           role,
   input  logic            phase_src,
   input  logic [CC_W-1:0] cc1_st,
   input  logic [CC_W-1:0] cc2_st,
   input  logic            vbus_ok,
   output att_e            state,
   output logic            orient,
   output logic [1:0]      lvl,
   output logic            present_src,
   output logic            cand_valid
);

   localparam int DEB_W = $clog2(DEBOUNCE + 1);
   localparam logic [DEB_W-1:0] DEB_LAST = DEB_W'(DEBOUNCE - 1);

   generate
      if (DEBOUNCE < 1) begin : g_bad_deb
         $error("tcpc_attach_fsm: DEBOUNCE must be at least 1");
      end
   endgenerate

   att_e             st_q;
   logic             or_q;
   logic [1:0]       lvl_q;
   logic [DEB_W-1:0] cnt;
   cand_t            cand, cand_q;
   logic [CC_W-1:0]  att_line, cand_line;

   function automatic logic open_or_ra(input logic [CC_W-1:0] c);
      return !is_rd(c) && !is_rp(c);
   endfunction

   always_comb begin
      case (role)
         ROLE_SRC: present_src = 1'b1;
         ROLE_SNK: present_src = 1'b0;
         default:  present_src = (st_q == ST_UNATT) ? phase_src
                                 : ((st_q == ST_SRC) || (st_q == ST_AUD));
      endcase
   end

   always_comb begin
      cand.kind   = ST_UNATT;
      cand.orient = 1'b0;
      if (run && st_q == ST_UNATT) begin
         if (present_src) begin
            if (is_ra(cc1_st) && is_ra(cc2_st)) begin
               cand.kind = ST_AUD;
            end else if (is_rd(cc1_st) && open_or_ra(cc2_st)) begin
               cand.kind = ST_SRC;
            end else if (is_rd(cc2_st) && open_or_ra(cc1_st)) begin
               cand.kind   = ST_SRC;
               cand.orient = 1'b1;
            end
         end else if (vbus_ok) begin
            if (is_rp(cc1_st) && !is_rp(cc2_st)) begin
               cand.kind = ST_SNK;
            end else if (is_rp(cc2_st) && !is_rp(cc1_st)) begin
               cand.kind   = ST_SNK;
               cand.orient = 1'b1;
            end
         end
      end
   end

   assign cand_valid = (cand.kind != ST_UNATT);
   assign att_line   = or_q ? cc2_st : cc1_st;
   assign cand_line  = cand.orient ? cc2_st : cc1_st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_UNATT;
         or_q   <= 1'b0;
         lvl_q  <= 2'd0;
         cnt    <= '0;
         cand_q <= '0;
      end else if (!run || restart) begin
         st_q   <= ST_UNATT;
         or_q   <= 1'b0;
         lvl_q  <= 2'd0;
         cnt    <= '0;
         cand_q <= '0;
      end else begin
         case (st_q)
            ST_UNATT: begin
               cand_q <= cand;
               if (!cand_valid || cand != cand_q) begin
                  cnt <= '0;
               end else if (cnt == DEB_LAST) begin
                  st_q  <= cand.kind;
                  or_q  <= cand.orient;
                  lvl_q <= rp_to_lvl(cand_line);
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_SRC: begin
               if (!is_rd(att_line)) begin
                  st_q   <= ST_UNATT;
                  or_q   <= 1'b0;
                  cand_q <= '0;
               end
            end
            ST_SNK: begin
               if (!is_rp(att_line) || !vbus_ok) begin
                  st_q   <= ST_UNATT;
                  or_q   <= 1'b0;
                  lvl_q  <= 2'd0;
                  cand_q <= '0;
               end else begin
                  lvl_q <= rp_to_lvl(att_line);
               end
            end
            default: begin
               if (!(is_ra(cc1_st) && is_ra(cc2_st))) begin
                  st_q   <= ST_UNATT;
                  cand_q <= '0;
               end
            end
         endcase
      end
   end

   assign state  = st_q;
   assign orient = or_q;
   assign lvl    = lvl_q;

   assert_sink_needs_vbus_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SNK && $past(st_q) == ST_UNATT) |-> $past(vbus_ok));

   assert_sink_drops_on_vbus_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SNK && !vbus_ok) |=> (st_q == ST_UNATT));

   assert_audio_as_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_AUD) |-> present_src);

   assert_idle_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (st_q == ST_UNATT));

   assert_source_presents_pullup_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SRC) |-> present_src);

endmodule

// File: rtl/tcpc_port_ctrl.sv
module tcpc_port_ctrl
   import tcpc_pkg::*;
#(
   parameter int TOGGLE_PERIOD = 32,
   parameter int DEBOUNCE      = 8,
   parameter bit DRP_START_SRC = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cc_en_n,
   input  logic       supply_ok,
   input  logic       soft_rst_req,
   input  logic [1:0] role_strap,
   input  logic [2:0] cc1_st,
   input  logic [2:0] cc2_st,
   input  logic       vbus_ok,
   input  logic [1:0] adv_level,
   input  logic       mux_en_n,
   output logic       term_on,
   output logic       term_src,
   output logic [1:0] rp_level,
   output logic       attached,
   output logic       mux_sel,
   output logic       mux_on,
   output logic       src_att_n,
   output logic       flip_n,
   output logic       snk_med_n,
   output logic       snk_high_n,
   output logic       audio_n
);

   logic       run, restart, phase_src, present_src, cand_valid, orient, data_att;
   role_e      role;
   att_e       state;
   logic [1:0] lvl;

   tcpc_role_latch u_role (
      .clk          (clk),
      .rst_n        (rst_n),
      .cc_en_n      (cc_en_n),
      .supply_ok    (supply_ok),
      .soft_rst_req (soft_rst_req),
      .role_strap   (role_strap),
      .run          (run),
      .restart      (restart),
      .role         (role)
   );

   tcpc_drp_toggle #(
      .PERIOD    (TOGGLE_PERIOD),
      .START_SRC (DRP_START_SRC)
   ) u_toggle (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run && role == ROLE_DRP && state == ST_UNATT && !restart),
      .hold      (cand_valid),
      .phase_src (phase_src)
   );

   tcpc_attach_fsm #(
      .DEBOUNCE (DEBOUNCE)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run),
      .restart     (restart),
      .role        (role),
      .phase_src   (phase_src),
      .cc1_st      (cc1_st),
      .cc2_st      (cc2_st),
      .vbus_ok     (vbus_ok),
      .state       (state),
      .orient      (orient),
      .lvl         (lvl),
      .present_src (present_src),
      .cand_valid  (cand_valid)
   );

   assign data_att   = (state == ST_SRC) || (state == ST_SNK);
   assign term_on    = run;
   assign term_src   = run && present_src;
   assign rp_level   = !term_src ? 2'd0 : (adv_level == 2'd0) ? 2'd0 :
                       (adv_level == 2'd1) ? 2'd1 : 2'd2;
   assign attached   = (state != ST_UNATT);
   assign mux_sel    = data_att && orient;
   assign mux_on     = data_att && !mux_en_n;
   assign src_att_n  = !(state == ST_SRC);
   assign flip_n     = !(data_att && orient);
   assign snk_med_n  = !(state == ST_SNK && lvl != 2'd0);
   assign snk_high_n = !(state == ST_SNK && lvl == 2'd2);
   assign audio_n    = !(state == ST_AUD);

   assert_mux_dir_agree_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mux_on |-> (flip_n == !mux_sel));

   assert_released_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !attached |-> (!mux_on && src_att_n && flip_n && audio_n && snk_med_n));

   assert_no_term_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !term_on |-> (!term_src && rp_level == 2'd0));

   assert_level_only_as_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rp_level != 2'd0) |-> term_src);

endmodule

// File: tb/tcpc_port_ctrl_test.sv
module tcpc_port_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int PER = 32;
   localparam int DEB = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cc_en_n = 1'b1, supply_ok = 1'b1, soft_rst_req = 1'b0, mux_en_n = 1'b0;
   logic [1:0] role_strap = 2'b01, adv_level = 2'd0;
   logic [2:0] cc1_st, cc2_st;
   logic vbus_ok;
   logic term_on, term_src, attached, mux_sel, mux_on, src_att_n, flip_n;
   logic snk_med_n, snk_high_n, audio_n;
   logic [1:0] rp_level;

   // partner model
   int p_kind = 0;
   logic p_or = 1'b0, p_vbus = 1'b0;
   logic [2:0] p_rp = 3'd3, raw1 = 3'd0, raw2 = 3'd0;
   logic raw_vb = 1'b0;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tcpc_port_ctrl #(.TOGGLE_PERIOD(PER), .DEBOUNCE(DEB)) uut (
      .clk(clk), .rst_n(rst_n), .cc_en_n(cc_en_n), .supply_ok(supply_ok),
      .soft_rst_req(soft_rst_req), .role_strap(role_strap), .cc1_st(cc1_st),
      .cc2_st(cc2_st), .vbus_ok(vbus_ok), .adv_level(adv_level), .mux_en_n(mux_en_n),
      .term_on(term_on), .term_src(term_src), .rp_level(rp_level), .attached(attached),
      .mux_sel(mux_sel), .mux_on(mux_on), .src_att_n(src_att_n), .flip_n(flip_n),
      .snk_med_n(snk_med_n), .snk_high_n(snk_high_n), .audio_n(audio_n));

   always_comb begin
      cc1_st = 3'd0; cc2_st = 3'd0; vbus_ok = 1'b0;
      case (p_kind)
         1: if (term_src) begin if (p_or) cc2_st = 3'd2; else cc1_st = 3'd2; end
         2: begin
               vbus_ok = p_vbus;
               if (term_on && !term_src) begin if (p_or) cc2_st = p_rp; else cc1_st = p_rp; end
            end
         3: if (term_src) begin cc1_st = 3'd1; cc2_st = 3'd1; end
         4: begin cc1_st = raw1; cc2_st = raw2; vbus_ok = raw_vb; end
         default: ;
      endcase
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_role(input logic [1:0] s);
      cc_en_n = 1'b1; step(2);
      role_strap = s; cc_en_n = 1'b0; step(2);
   endtask

   task automatic wait_attach(input int lim);
      for (int i = 0; i < lim && !attached; i++) step(1);
   endtask

   function automatic bit f_rd(input logic [2:0] c); return c == 3'd2; endfunction
   function automatic bit f_rp(input logic [2:0] c); return c >= 3'd3 && c <= 3'd5; endfunction
   function automatic bit f_ra(input logic [2:0] c); return c == 3'd1; endfunction

   // 0 none, 1 source on line1, 2 source on line2, 3 audio
   function automatic int exp_src(input logic [2:0] a, input logic [2:0] b);
      if (f_ra(a) && f_ra(b)) return 3;
      if (f_rd(a) && !f_rd(b) && !f_rp(b)) return 1;
      if (f_rd(b) && !f_rd(a) && !f_rp(a)) return 2;
      return 0;
   endfunction

   // 0 none, 1 line1, 2 line2
   function automatic int exp_snk(input logic [2:0] a, input logic [2:0] b, input logic v);
      if (!v) return 0;
      if (f_rp(a) && !f_rp(b)) return 1;
      if (f_rp(b) && !f_rp(a)) return 2;
      return 0;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int k, e, ones, edges;
      logic prev;
      void'($urandom(32'h1c0de));
      step(3); rst_n = 1'b1; step(2);
      chk(!term_on && !attached && src_att_n && flip_n && audio_n && snk_med_n && snk_high_n
          && !mux_on, "R11 reset state", attached, 0);

      // source only role and advertised level
      set_role(2'b10);
      chk(term_on && term_src, "R1 strap high gives source", term_src, 1);
      for (int a = 0; a < 4; a++) begin
         adv_level = 2'(a); step(1);
         chk(rp_level == ((a == 0) ? 0 : (a == 1) ? 1 : 2), "R7 advertised level", rp_level,
             (a == 0) ? 0 : (a == 1) ? 1 : 2);
      end

      // strap change ignored, then soft reset picks it up
      role_strap = 2'b00; step(20);
      chk(term_src == 1'b1, "R2 strap ignored while active", term_src, 1);
      soft_rst_req = 1'b1; step(1); soft_rst_req = 1'b0; step(2);
      chk(term_on && !term_src, "R2 soft reset recaptures sink", term_src, 0);
      for (int a = 0; a < 4; a++) begin
         adv_level = 2'(a); step(1);
         chk(rp_level == 0, "R7 level ignored as sink", rp_level, 0);
      end

      // random sink patterns
      p_kind = 4;
      for (int i = 0; i < 14; i++) begin
         raw1 = 3'($urandom % 8); raw2 = 3'($urandom % 8); raw_vb = 1'($urandom % 4 != 0);
         if (i == 0) begin raw1 = 3'd5; raw2 = 3'd0; raw_vb = 1'b0; end
         if (i == 1) begin raw1 = 3'd4; raw2 = 3'd3; raw_vb = 1'b1; end
         e = exp_snk(raw1, raw2, raw_vb);
         adv_level = 2'($urandom % 4);
         step(DEB + 4);
         k = (e == 0) ? 0 : f_rp(e == 1 ? raw1 : raw2) ? ((e == 1 ? raw1 : raw2) - 3) : 0;
         chk(attached == (e != 0), "R6 sink attach decision", attached, e != 0);
         chk(snk_med_n == !(e != 0 && k >= 1) && snk_high_n == !(e != 0 && k == 2),
             "R6 sink level report", {snk_med_n, snk_high_n}, {!(e != 0 && k >= 1), !(e != 0 && k == 2)});
         chk(rp_level == 0 && src_att_n, "R7 sink presents no level", rp_level, 0);
         if (e != 0) begin
            raw_vb = 1'b0; step(2);
            chk(!attached, "R10 sink detach on VBUS loss", attached, 0);
         end
         raw1 = 3'd0; raw2 = 3'd0; step(2);
      end

      // random source patterns
      p_kind = 0; set_role(2'b10); p_kind = 4;
      for (int i = 0; i < 16; i++) begin
         raw1 = 3'($urandom % 8); raw2 = 3'($urandom % 8);
         if (i == 0) begin raw1 = 3'd2; raw2 = 3'd2; end
         if (i == 1) begin raw1 = 3'd2; raw2 = 3'd4; end
         if (i == 2) begin raw1 = 3'd1; raw2 = 3'd1; end
         if (i == 3) begin raw1 = 3'd1; raw2 = 3'd2; end
         e = exp_src(raw1, raw2);
         step(DEB + 4);
         chk(attached == (e != 0), "R4 source attach decision", attached, e != 0);
         chk(src_att_n == !(e == 1 || e == 2), "R5 source indicator", src_att_n, !(e == 1 || e == 2));
         chk(flip_n == (e != 2) && mux_sel == (e == 2), "R4 orientation to mux", mux_sel, e == 2);
         chk(audio_n == (e != 3) && (e != 3 || !mux_on), "R8 audio indicator", audio_n, e != 3);
         raw1 = 3'd0; raw2 = 3'd0; step(2);
         chk(!attached && src_att_n && audio_n && flip_n, "R10 release on removal", attached, 0);
      end

      // debounce window and mux enable
      raw1 = 3'd2; raw2 = 3'd0; step(DEB / 2);
      chk(!attached, "R4 no attach inside debounce", attached, 0);
      step(DEB);
      chk(attached && mux_on, "R4 attach after debounce", attached, 1);
      mux_en_n = 1'b1; step(1);
      chk(!mux_on && attached, "R9 mux shutdown", mux_on, 0);
      mux_en_n = 1'b0; step(1);
      chk(mux_on, "R9 mux restored", mux_on, 1);
      raw1 = 3'd0; step(2);

      // dual-role toggling
      p_kind = 0; set_role(2'b01);
      ones = 0; edges = 0; prev = term_src;
      for (int i = 0; i < 2 * PER; i++) begin
         step(1);
         if (term_src) ones++;
         if (term_src != prev) edges++;
         prev = term_src;
      end
      chk(ones == PER, "R3 half of each period as source", ones, PER);
      chk(edges >= 3, "R3 presentation alternates", edges, 4);

      // dual-role meets a sink partner on line 2
      p_kind = 1; p_or = 1'b1; wait_attach(4 * PER);
      chk(attached && !src_att_n && !flip_n && mux_sel, "R5 dual-role resolved to source",
          src_att_n, 0);
      p_kind = 0; step(2);
      chk(!attached && src_att_n && flip_n, "R10 detach releases outputs", attached, 0);
      ones = 0;
      for (int i = 0; i < 2 * PER; i++) begin step(1); if (term_src) ones++; end
      chk(ones > 0 && ones < 2 * PER, "R10 toggling resumes", ones, PER);

      // dual-role meets a source partner on line 1
      p_kind = 2; p_or = 1'b0; p_rp = 3'd5; p_vbus = 1'b1; wait_attach(4 * PER);
      chk(attached && src_att_n && !term_src && !snk_med_n && !snk_high_n && !mux_sel,
          "R6 dual-role resolved to sink at 3 A", {snk_med_n, snk_high_n}, 0);
      p_vbus = 1'b0; step(2);
      chk(!attached, "R10 VBUS loss detaches", attached, 0);

      // dual-role audio adapter
      p_kind = 3; wait_attach(4 * PER);
      chk(attached && !audio_n && !mux_on && src_att_n, "R8 audio adapter", audio_n, 0);
      p_kind = 0; step(2);

      // disable paths
      cc_en_n = 1'b1; step(3);
      chk(!term_on && !attached, "R11 disabled by enable", term_on, 0);
      cc_en_n = 1'b0; supply_ok = 1'b0; step(3);
      chk(!term_on && !term_src, "R11 disabled by supply", term_on, 0);
      supply_ok = 1'b1; step(3);
      chk(term_on, "R1 active again", term_on, 1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule